// File: doc/BRIEF.md
# Asynchronous Burst Read Bus Master

This block lets synchronous logic fetch short bursts of 32-bit words from a peripheral that sits on an asynchronous, strobe-timed parallel bus. A requester hands over a word address and a beat count (1 to 8). The controller then drives an active-low chip select and read strobe low together. It keeps them low for the whole burst and steps the low three word-address bits once per beat. It captures the data bus at the end of each beat and releases both strobes after the last word.

The bus timing is given in nanoseconds: the address cycle time, address-to-data delay, strobe-to-data delay, strobe high time and data turn-off time. These values become whole clock counts by ceiling division against the clock period, so one block can serve many clock rates. Each captured word leaves on a valid/ready port. If the consumer is not ready, the controller holds the bus state and waits, so no word is lost and none is delivered twice. A request whose burst would cross an aligned 8-word window is refused with a one-cycle error pulse.

Top module: `burst_rd_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, bus_cs_n and bus_rd_n are 1, out_valid is 0, req_err is 0 and req_ready is 1.
- R2: bus_cs_n and bus_rd_n are always equal. Both go low on the clock edge that accepts a valid request, and on that same edge bus_addr takes req_addr.
- R3: During a burst, bus_addr bits above bit 2 stay constant. Each beat changes only bits [2:0], which increase by exactly one.
- R4: With BEAT = max(ceil(T_ACYC/CLK_NS), ceil(T_ADV/CLK_NS)), the first address of a burst is held at least max(BEAT, ceil(T_CSDV/CLK_NS)) cycles and every later address at least BEAT cycles. Exactly those counts apply when out_ready stays 1.
- R5: Each beat delivers the bus_data word present at the end of its hold as one out_valid/out_ready transfer, in address order. out_last is 1 only on the final word of a burst.
- R6: While out_valid is 1 and out_ready is 0, out_data and out_last stay unchanged and bus_addr does not advance.
- R7: Between two bursts, the strobes stay high for at least max(ceil(T_CSH/CLK_NS), ceil(T_DOFF/CLK_NS), 1) + 1 cycles.
- R8: A request with req_len of 0, req_len above 8, or req_addr[2:0] + req_len above 8 is accepted and refused. req_err is 1 for the one cycle after the accepting edge, and the strobes stay high.
- R9: req_ready is 1 only while no burst is active or winding down, and is never 1 while the strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | AW | Start word address |
| req_len | input | LW | Number of beats, 1 to BEATS |
| req_err | output | 1 | One-cycle pulse for a refused request |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_addr | output | AW | Word address to the peripheral |
| bus_data | input | DW | Read data from the peripheral |
| out_valid | output | 1 | Captured word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | DW | Captured word |
| out_last | output | 1 | Word is the final beat of its burst |

## Verification
The hardest case is a stall on the final beat while a new request is waiting. The last word must stay held on the output while the strobes are released, the high interval runs, and the next burst starts. The bench reaches this case by issuing back-to-back requests while the ready line follows a pseudo-random pattern and then long low stretches. The bus model returns a poison value unless the address and strobes have been steady for the required delays. A beat cut short therefore shows up as a bad word in the scoreboard, not only as a timing mismatch.

// File: rtl/brm_pkg.sv
package brm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_GAP  = 2'd2
   } brm_state_e;

   function automatic int unsigned brm_cdiv(int unsigned ns, int unsigned per);
      return (ns + per - 1) / per;
   endfunction

   function automatic int unsigned brm_max(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/brm_req_check.sv
module brm_req_check #(
   parameter int BEATS = 8,
   parameter int LB    = 3,
   parameter int LW    = 4
) (
   input  logic [LB-1:0] addr_lo,
   input  logic [LW-1:0] len,
   output logic          ok
);
   logic [LW:0] span;

   always_comb begin
      span = {{(LW+1-LB){1'b0}}, addr_lo} + {1'b0, len};
      ok   = (len != '0) && ({1'b0, len} <= (LW+1)'(BEATS)) && (span <= (LW+1)'(BEATS));
   end
endmodule

// File: rtl/brm_beat_timer.sv
module brm_beat_timer #(
   parameter int TW   = 3,
   parameter int MAXC = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [TW-1:0] cnt
);
   localparam logic [TW-1:0] TOP = TW'(MAXC);

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= TOP;
      else if (clr)      cnt <= '0;
      else if (cnt < TOP) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/brm_out_reg.sv
module brm_out_reg #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] din,
   input  logic          last_in,
   output logic          free,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data,
   output logic          out_last
);
   assign free = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_data  <= din;
         out_last  <= last_in;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/burst_rd_master.sv
module burst_rd_master
   import brm_pkg::*;
#(
   parameter int AW     = 30,
   parameter int DW     = 32,
   parameter int BEATS  = 8,
   parameter int CLK_NS = 20,
   parameter int T_ACYC = 45,
   parameter int T_ADV  = 40,
   parameter int T_CSDV = 30,
   parameter int T_CSH  = 13,
   parameter int T_DOFF = 9,
   localparam int LB    = $clog2(BEATS),
   localparam int LW    = $clog2(BEATS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [LW-1:0] req_len,
   output logic          req_err,
   output logic          bus_cs_n,
   output logic          bus_rd_n,
   output logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data,
   output logic          out_last
);
   localparam int unsigned ACYC_C  = brm_cdiv(T_ACYC, CLK_NS);
   localparam int unsigned ADV_C   = brm_cdiv(T_ADV, CLK_NS);
   localparam int unsigned CSDV_C  = brm_cdiv(T_CSDV, CLK_NS);
   localparam int unsigned CSH_C   = brm_cdiv(T_CSH, CLK_NS);
   localparam int unsigned DOFF_C  = brm_cdiv(T_DOFF, CLK_NS);
   localparam int unsigned BEAT_C  = brm_max(brm_max(ACYC_C, ADV_C), 1);
   localparam int unsigned FIRST_C = brm_max(BEAT_C, CSDV_C);
   localparam int unsigned GAP_C   = brm_max(brm_max(CSH_C, DOFF_C), 1);
   localparam int unsigned MAXW    = brm_max(FIRST_C, GAP_C);
   localparam int          TW      = $clog2(MAXW + 1);
   localparam logic [TW-1:0] FIRST_M1 = TW'(FIRST_C - 1);
   localparam logic [TW-1:0] BEAT_M1  = TW'(BEAT_C - 1);
   localparam logic [TW-1:0] GAP_M1   = TW'(GAP_C - 1);

   generate
      if (CLK_NS < 1)
         $error("burst_rd_master: CLK_NS must be positive");
      if (BEATS < 2 || (1 << LB) != BEATS)
         $error("burst_rd_master: BEATS must be a power of two of at least 2");
      if (AW <= LB)
         $error("burst_rd_master: AW must exceed the burst index width");
   endgenerate

   brm_state_e    state;
   logic          strb_n;
   logic          first_q;
   logic [LW-1:0] left_q;
   logic [TW-1:0] tcnt;
   logic          req_ok;
   logic          hs;
   logic          beat_due;
   logic          out_free;
   logic          take;
   logic          last_beat;

   assign req_ready = (state == ST_IDLE);
   assign hs        = req_valid && req_ready;
   assign last_beat = (left_q == LW'(1));
   assign beat_due  = (state == ST_RUN) && (tcnt >= (first_q ? FIRST_M1 : BEAT_M1));
   assign take      = beat_due && out_free;
   assign bus_cs_n  = strb_n;
   assign bus_rd_n  = strb_n;

   brm_req_check #(.BEATS(BEATS), .LB(LB), .LW(LW)) u_check (
      .addr_lo (req_addr[LB-1:0]),
      .len     (req_len),
      .ok      (req_ok)
   );

   brm_beat_timer #(.TW(TW), .MAXC(MAXW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   ((hs && req_ok) || take),
      .cnt   (tcnt)
   );

   brm_out_reg #(.DW(DW)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (take),
      .din       (bus_data),
      .last_in   (last_beat),
      .free      (out_free),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_last  (out_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         strb_n   <= 1'b1;
         first_q  <= 1'b0;
         left_q   <= '0;
         bus_addr <= '0;
         req_err  <= 1'b0;
      end else begin
         req_err <= hs && !req_ok;
         unique case (state)
            ST_IDLE: begin
               if (hs && req_ok) begin
                  state    <= ST_RUN;
                  strb_n   <= 1'b0;
                  first_q  <= 1'b1;
                  left_q   <= req_len;
                  bus_addr <= req_addr;
               end
            end
            ST_RUN: begin
               if (take) begin
                  first_q <= 1'b0;
                  if (last_beat) begin
                     state  <= ST_GAP;
                     strb_n <= 1'b1;
                  end else begin
                     left_q   <= left_q - 1'b1;
                     bus_addr <= {bus_addr[AW-1:LB], bus_addr[LB-1:0] + 1'b1};
                  end
               end
            end
            ST_GAP: begin
               if (tcnt >= GAP_M1) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/brm_chk.sv
module brm_chk #(
   parameter int AW    = 30,
   parameter int DW    = 32,
   parameter int LB    = 3,
   parameter int GAP_C = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          req_err,
   input logic          bus_cs_n,
   input logic [AW-1:0] bus_addr,
   input logic          out_valid,
   input logic          out_ready,
   input logic [DW-1:0] out_data
);
   logic [15:0] hi_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                     hi_cnt <= 16'hFFFF;
      else if (!bus_cs_n)             hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF)    hi_cnt <= hi_cnt + 1'b1;
   end

   assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_cs_n |-> !req_ready);

   assert_upper_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && $past(!bus_cs_n)) |-> (bus_addr[AW-1:LB] == $past(bus_addr[AW-1:LB])));

   assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_err_after_hs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> $past(req_valid && req_ready));

   assert_err_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> bus_cs_n);

   assert_gap_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_cs_n) |-> (hi_cnt >= 16'(GAP_C)));
endmodule

bind burst_rd_master brm_chk #(.AW(AW), .DW(DW), .LB(LB), .GAP_C(GAP_C)) u_brm_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_err   (req_err),
   .bus_cs_n  (bus_cs_n),
   .bus_addr  (bus_addr),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data)
);

// File: tb/burst_rd_master_bench.sv
module burst_rd_master_bench;
   localparam int AW = 30, DW = 32, LW = 4;
   localparam int CLK_NS = 20;
   localparam int ACYC_C  = (45 + CLK_NS - 1) / CLK_NS;
   localparam int ADV_C   = (40 + CLK_NS - 1) / CLK_NS;
   localparam int CSDV_C  = (30 + CLK_NS - 1) / CLK_NS;
   localparam int CSH_C   = (13 + CLK_NS - 1) / CLK_NS;
   localparam int DOFF_C  = (9 + CLK_NS - 1) / CLK_NS;
   localparam int BEAT_C  = (ACYC_C > ADV_C) ? ACYC_C : ADV_C;
   localparam int FIRST_C = (BEAT_C > CSDV_C) ? BEAT_C : CSDV_C;
   localparam int GAP_C   = (CSH_C > DOFF_C) ? ((CSH_C > 1) ? CSH_C : 1) : ((DOFF_C > 1) ? DOFF_C : 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready, req_err;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic bus_cs_n, bus_rd_n;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_data;
   logic out_valid, out_ready = 1'b1, out_last;
   logic [DW-1:0] out_data;

   int nchk = 0, nerr = 0, cyc = 0, mode = 0;
   bit done = 0;
   logic [DW:0] exp_q[$];

   burst_rd_master u_burst_rd_master (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .req_err(req_err),
      .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_addr(bus_addr), .bus_data(bus_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
   );

   always #10 clk = ~clk;

   function automatic logic [DW-1:0] word_of(logic [AW-1:0] a);
      return (DW'(a) * 32'h9E37_79B1) ^ 32'h1234_5678;
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Peripheral model: data is valid only once address and strobes have settled.
   logic [AW-1:0] p_addr = '0;
   logic p_cs = 1'b1;
   int a_age = 0, cs_age = 0;
   always @(posedge clk) begin
      p_addr <= bus_addr;
      p_cs   <= bus_cs_n;
      if (bus_addr != p_addr) a_age <= 1; else if (a_age < 1000) a_age <= a_age + 1;
      if (bus_cs_n) cs_age <= 0; else if (cs_age < 1000) cs_age <= cs_age + 1;
   end
   assign bus_data = (!bus_cs_n && !bus_rd_n && !p_cs && bus_addr == p_addr &&
                      a_age >= ADV_C - 1 && cs_age >= CSDV_C - 1) ? word_of(bus_addr) : 32'hBAD0_BAD0;

   // Consumer ready patterns
   logic [15:0] lfsr = 16'hACE1;
   always @(posedge clk) begin
      #1;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
         0: out_ready = 1'b1;
         1: out_ready = lfsr[0];
         default: out_ready = ((cyc % 9) > 5);
      endcase
   end

   // Monitor: scoreboard and bus timing checks at the falling edge
   logic [AW-1:0] m_addr = '0;
   logic m_cs = 1'b1, stall_prev = 1'b0, m_first = 1'b0, seen_rel = 1'b0;
   logic [DW-1:0] stall_data = '0;
   logic stall_last = 1'b0;
   int last_chg = 0, rel_cyc = 0;
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (bus_cs_n != bus_rd_n) chk(0, "R2", "strobes differ", bus_cs_n, bus_rd_n);
         if (req_ready && !bus_cs_n) chk(0, "R9", "ready with strobes low", 1, 0);
         if (stall_prev) begin
            chk(out_valid && out_data == stall_data && out_last == stall_last, "R6",
                "stalled word changed", out_data, stall_data);
            if (!m_cs && !bus_cs_n)
               chk(bus_addr == m_addr, "R6", "address advanced in stall", bus_addr, m_addr);
         end
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) chk(0, "R5", "unexpected word", out_data, 0);
            else begin
               logic [DW:0] e;
               e = exp_q.pop_front();
               chk(out_data == e[DW-1:0], "R5", "word", out_data, e[DW-1:0]);
               chk(out_last == e[DW], "R5", "last flag", out_last, e[DW]);
            end
         end
         if (!bus_cs_n && m_cs) begin
            if (seen_rel) chk(cyc - rel_cyc >= GAP_C + 1, "R7", "strobe high time", cyc - rel_cyc, GAP_C + 1);
            last_chg = cyc; m_first = 1'b1;
         end else if (!bus_cs_n && !m_cs && bus_addr != m_addr) begin
            int need = m_first ? FIRST_C : BEAT_C;
            if (mode == 0) chk(cyc - last_chg == need, "R4", "beat length", cyc - last_chg, need);
            else           chk(cyc - last_chg >= need, "R4", "beat length", cyc - last_chg, need);
            chk(bus_addr[AW-1:3] == m_addr[AW-1:3], "R3", "upper bits", bus_addr, m_addr);
            chk(bus_addr[2:0] == m_addr[2:0] + 3'd1, "R3", "low step", bus_addr[2:0], m_addr[2:0] + 3'd1);
            last_chg = cyc; m_first = 1'b0;
         end else if (bus_cs_n && !m_cs) begin
            int need = m_first ? FIRST_C : BEAT_C;
            chk(cyc - last_chg >= need, "R4", "final beat length", cyc - last_chg, need);
            rel_cyc = cyc; seen_rel = 1'b1;
         end
      end
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
      stall_last = out_last;
      m_addr = bus_addr;
      m_cs = bus_cs_n;
   end

   // Driver: pushes expected words, then issues the request
   task automatic burst(logic [AW-1:0] a, int n);
      for (int i = 0; i < n; i++)
         exp_q.push_back({(i == n - 1), word_of({a[AW-1:3], a[2:0] + 3'(i)})});
      req_addr = a; req_len = LW'(n); req_valid = 1'b1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1 req_valid = 1'b0;
      @(negedge clk);
      chk(!bus_cs_n && !bus_rd_n, "R2", "strobes low after accept", bus_cs_n, 0);
      chk(bus_addr == a, "R2", "start address", bus_addr, a);
      chk(!req_ready, "R9", "ready low during burst", req_ready, 0);
      @(posedge clk); #1;
   endtask

   task automatic bad(logic [AW-1:0] a, int n);
      req_addr = a; req_len = LW'(n); req_valid = 1'b1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1 req_valid = 1'b0;
      @(negedge clk);
      chk(req_err == 1'b1, "R8", "error pulse", req_err, 1);
      chk(bus_cs_n == 1'b1, "R8", "no strobe on refusal", bus_cs_n, 1);
      @(negedge clk);
      chk(req_err == 1'b0 && bus_cs_n == 1'b1, "R8", "error one cycle only", req_err, 0);
      @(posedge clk); #1;
   endtask

   task automatic drain();
      while (exp_q.size() != 0 || !req_ready || out_valid) @(negedge clk);
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(bus_cs_n && bus_rd_n && !out_valid && !req_err && req_ready, "R1", "reset state",
          {bus_cs_n, bus_rd_n, out_valid, req_err, req_ready}, 5'b11001);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk(bus_cs_n && !out_valid && req_ready, "R1", "after reset", {bus_cs_n, out_valid, req_ready}, 3'b101);
      @(posedge clk); #1;

      mode = 0;
      burst(30'h0000_0100, 8);
      drain();
      burst(30'h0123_4563, 5);
      drain();
      burst(30'h0ABC_DE05, 3);
      burst(30'h0000_0777, 1);
      drain();

      bad(30'h0000_0015, 4);
      bad(30'h0000_0010, 0);
      bad(30'h0000_0020, 9);

      mode = 1;
      burst(30'h0300_0040, 8);
      burst(30'h0300_0052, 4);
      burst(30'h0300_0066, 2);
      drain();

      mode = 2;
      burst(30'h1555_5558, 8);
      burst(30'h1555_5567, 1);
      drain();

      mode = 0;
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R5", "scoreboard empty", exp_q.size(), 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end
endmodule